// File: doc/BRIEF.md
# Execution Trace Reporting Unit

This unit sits beside a processor pipeline and drives an external trace port. From that port an observer can rebuild the exact instruction stream, even when instructions and data are served from on-chip caches. Each core cycle the write-back stage presents at most one retiring event: a sequential instruction, a taken branch or an interrupt with its physical target, or a load or store with its physical address and a flag saying the access allocated a cache block. The unit turns that event into an address bus value, request, read/write and instruction/data strobes and a 3-bit status code.

A control bit turns tracing on. While it is off the port only mirrors genuine off-chip accesses. In full-rate mode every core cycle gives one port report. In half-rate mode the core runs at twice the port speed. A phase state machine pairs core cycles into port cycles and keeps one event per pair by a fixed priority. When nothing needs an address, the bus carries the genuine off-chip access inputs, and the status code still describes the retiring instruction.

The phase state machine has four states. `PH_OFF` is entered whenever tracing is disabled. `PH_FULL` is entered whenever tracing is enabled and half-rate is clear. `PH_HALF_EVEN` and `PH_HALF_ODD` are used in half-rate operation. The transitions are:
- *disable*: any state goes to `PH_OFF`.
- *go_full*: any state goes to `PH_FULL`.
- *capture*: `PH_OFF`, `PH_FULL` or `PH_HALF_EVEN` goes to `PH_HALF_ODD`, storing the event.
- *commit*: `PH_HALF_ODD` goes to `PH_HALF_EVEN`, updating the port.

Top module: `trace_port_unit`

## Requirements
- R1: While `rst_n` is low, every port output is zero and the half-rate phase returns to even.
- R2: Event kind encoding on `ev_kind` is 0 none, 1 sequential, 2 taken branch, 3 interrupt/trap, 4 load, 5 store; codes 6 and 7 act as none. In full-rate mode a branch or interrupt drives `pa_addr` = target, `pa_req`=1, `pa_rw`=1 (read), `pa_id`=1 (instruction), `pa_alloc`=0, and status 010 (branch) or 011 (interrupt).
- R3: A sequential or empty event makes no address report. The bus carries `mem_addr`, `mem_req`, `mem_rw` and `mem_id`, `pa_alloc` is 0, and status is 001 for sequential and 000 for none.
- R4: A load or store is reported at write-back, whatever the cache outcome. `pa_addr` is the data address, `pa_req`=1, `pa_id`=0, `pa_rw`=1 for a load and 0 for a store, and status is 100 for a load and 101 for a store.
- R5: A load or store with `ev_alloc`=1 sets `pa_alloc`=1, and its status becomes 110 (load) or 111 (store).
- R6: In full-rate mode the port shows an event's report exactly one clock edge after the event is sampled.
- R7: With `trace_en`=0, events have no effect. The port is the off-chip access inputs registered one clock, with status 000 and `pa_alloc`=0.
- R8: With tracing enabled and `half_rate`=1, edges alternate between capture and commit, starting with capture after any non-half-rate edge. The port holds its value across capture edges and changes only on commit edges.
- R9: In half-rate mode, if both events of a port cycle are branches or interrupts, only the second one is reported.
- R10: In half-rate mode, a branch or interrupt paired with a load or store is reported in place of the memory access, in either order.
- R11: Otherwise in half-rate mode the higher class wins (memory over sequential over none), and on a tie the second event wins. An unaddressed winner passes the off-chip inputs sampled at the commit edge through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Tracing enable control bit |
| half_rate | input | 1 | 1: port runs at half the core rate |
| ev_kind | input | 3 | Retiring event kind (see R2) |
| ev_addr | input | AW | Branch target or data physical address |
| ev_alloc | input | 1 | Load/store allocated a cache block |
| mem_req | input | 1 | Genuine off-chip access request |
| mem_addr | input | AW | Genuine off-chip access address |
| mem_rw | input | 1 | Genuine access read (1) / write (0) |
| mem_id | input | 1 | Genuine access instruction (1) / data (0) |
| pa_addr | output | AW | Trace port address bus |
| pa_req | output | 1 | Trace port request strobe |
| pa_rw | output | 1 | Trace port read/write strobe |
| pa_id | output | 1 | Trace port instruction/data strobe |
| pa_alloc | output | 1 | Cache block allocation flag |
| pa_stat | output | 3 | Retirement status code |

## Verification
The assertions take for granted that `trace_en` and `half_rate` are synchronous levels settled before each rising edge. They also assume `ev_kind` describes at most one retiring instruction per core cycle, and that the off-chip access inputs are valid whenever they are sampled. The stimulus keeps within this by changing every input only on the falling edge. It holds each mode for a long run of cycles, and it also switches mode at arbitrary phases, odd and even. Event kinds, including the unused codes 6 and 7, addresses and allocation flags are drawn freely within those rules.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int KIND_W = 3;
    localparam int STAT_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_NONE   = 3'd0,
        K_SEQ    = 3'd1,
        K_BRANCH = 3'd2,
        K_TRAP   = 3'd3,
        K_LOAD   = 3'd4,
        K_STORE  = 3'd5
    } ev_kind_e;

    typedef enum logic [STAT_W-1:0] {
        S_IDLE   = 3'd0,
        S_SEQ    = 3'd1,
        S_BRANCH = 3'd2,
        S_TRAP   = 3'd3,
        S_LOAD   = 3'd4,
        S_STORE  = 3'd5,
        S_LOAD_A = 3'd6,
        S_STORE_A= 3'd7
    } stat_e;

    // Priority class of a report inside one half-rate port cycle
    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_SEQ  = 2'd1,
        RK_MEM  = 2'd2,
        RK_JUMP = 2'd3
    } rank_e;

    typedef struct packed {
        logic  req;
        logic  rw;
        logic  id;
        logic  alloc;
        stat_e stat;
        rank_e rank;
    } rpt_t;

    typedef enum logic [1:0] {
        PH_OFF       = 2'd0,
        PH_FULL      = 2'd1,
        PH_HALF_EVEN = 2'd2,
        PH_HALF_ODD  = 2'd3
    } phase_e;

endpackage

// File: rtl/trace_event_encoder.sv
module trace_event_encoder
    import trace_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [AW-1:0]     addr,
    input  logic              alloc,
    output rpt_t              rpt,
    output logic [AW-1:0]     rpt_addr
);

    always_comb begin
        rpt      = '0;
        rpt_addr = '0;
        case (kind)
            K_SEQ: begin
                rpt.stat = S_SEQ;
                rpt.rank = RK_SEQ;
            end
            K_BRANCH, K_TRAP: begin
                rpt.req  = 1'b1;
                rpt.rw   = 1'b1;
                rpt.id   = 1'b1;
                rpt.stat = (kind == K_TRAP) ? S_TRAP : S_BRANCH;
                rpt.rank = RK_JUMP;
                rpt_addr = addr;
            end
            K_LOAD: begin
                rpt.req   = 1'b1;
                rpt.rw    = 1'b1;
                rpt.alloc = alloc;
                rpt.stat  = alloc ? S_LOAD_A : S_LOAD;
                rpt.rank  = RK_MEM;
                rpt_addr  = addr;
            end
            K_STORE: begin
                rpt.req   = 1'b1;
                rpt.alloc = alloc;
                rpt.stat  = alloc ? S_STORE_A : S_STORE;
                rpt.rank  = RK_MEM;
                rpt_addr  = addr;
            end
            default: begin
                rpt.stat = S_IDLE;
                rpt.rank = RK_NONE;
            end
        endcase
    end

endmodule

// File: rtl/trace_phase_fsm.sv
module trace_phase_fsm
    import trace_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trace_en,
    input  logic half_rate,
    output logic act_off,
    output logic act_full,
    output logic act_capture,
    output logic act_commit
);

    phase_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!trace_en)       state_d = PH_OFF;
        else if (!half_rate) state_d = PH_FULL;
        else begin
            unique case (state_q)
                PH_OFF, PH_FULL, PH_HALF_EVEN: state_d = PH_HALF_ODD;
                PH_HALF_ODD:                   state_d = PH_HALF_EVEN;
                default:                       state_d = PH_OFF;
            endcase
        end
    end

    // action outputs
    always_comb begin
        act_off     = 1'b0;
        act_full    = 1'b0;
        act_capture = 1'b0;
        act_commit  = 1'b0;
        if (!trace_en)       act_off  = 1'b1;
        else if (!half_rate) act_full = 1'b1;
        else begin
            unique case (state_q)
                PH_HALF_ODD: act_commit  = 1'b1;
                default:     act_capture = 1'b1;
            endcase
        end
    end

    p_phase_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && half_rate && state_q == PH_HALF_ODD) |=> state_q == PH_HALF_EVEN);

    p_phase_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_capture |=> state_q == PH_HALF_ODD);

    p_off_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> state_q == PH_OFF);

    p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({act_off, act_full, act_capture, act_commit}) == 1);

endmodule

// File: rtl/trace_pair_merge.sv
module trace_pair_merge
    import trace_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  rpt_t          cur_rpt,
    input  logic [AW-1:0] cur_addr,
    output rpt_t          sel_rpt,
    output logic [AW-1:0] sel_addr
);

    rpt_t          held_rpt;
    logic [AW-1:0] held_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_rpt  <= '0;
            held_addr <= '0;
        end else if (capture) begin
            held_rpt  <= cur_rpt;
            held_addr <= cur_addr;
        end
    end

    // Later event wins ties; higher class always wins.
    always_comb begin
        if (cur_rpt.rank >= held_rpt.rank) begin
            sel_rpt  = cur_rpt;
            sel_addr = cur_addr;
        end else begin
            sel_rpt  = held_rpt;
            sel_addr = held_addr;
        end
    end

    p_held_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(held_rpt) && $stable(held_addr));

endmodule

// File: rtl/trace_port_unit.sv
module trace_port_unit
    import trace_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              half_rate,
    input  logic [KIND_W-1:0] ev_kind,
    input  logic [AW-1:0]     ev_addr,
    input  logic              ev_alloc,
    input  logic              mem_req,
    input  logic [AW-1:0]     mem_addr,
    input  logic              mem_rw,
    input  logic              mem_id,
    output logic [AW-1:0]     pa_addr,
    output logic              pa_req,
    output logic              pa_rw,
    output logic              pa_id,
    output logic              pa_alloc,
    output logic [STAT_W-1:0] pa_stat
);

    rpt_t          enc_rpt, mrg_rpt, src_rpt;
    logic [AW-1:0] enc_addr, mrg_addr, src_addr;
    logic          act_off, act_full, act_capture, act_commit;

    logic [AW-1:0]     nxt_addr;
    logic              nxt_req, nxt_rw, nxt_id, nxt_alloc;
    logic [STAT_W-1:0] nxt_stat;

    trace_event_encoder #(.AW(AW)) enc_i (
        .kind     (ev_kind),
        .addr     (ev_addr),
        .alloc    (ev_alloc),
        .rpt      (enc_rpt),
        .rpt_addr (enc_addr)
    );

    trace_phase_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .trace_en    (trace_en),
        .half_rate   (half_rate),
        .act_off     (act_off),
        .act_full    (act_full),
        .act_capture (act_capture),
        .act_commit  (act_commit)
    );

    trace_pair_merge #(.AW(AW)) mrg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (act_capture),
        .cur_rpt  (enc_rpt),
        .cur_addr (enc_addr),
        .sel_rpt  (mrg_rpt),
        .sel_addr (mrg_addr)
    );

    always_comb begin
        src_rpt  = act_full ? enc_rpt  : mrg_rpt;
        src_addr = act_full ? enc_addr : mrg_addr;
        if (!act_off && src_rpt.req) begin
            nxt_addr  = src_addr;
            nxt_req   = 1'b1;
            nxt_rw    = src_rpt.rw;
            nxt_id    = src_rpt.id;
            nxt_alloc = src_rpt.alloc;
            nxt_stat  = src_rpt.stat;
        end else begin
            nxt_addr  = mem_addr;
            nxt_req   = mem_req;
            nxt_rw    = mem_rw;
            nxt_id    = mem_id;
            nxt_alloc = 1'b0;
            nxt_stat  = act_off ? S_IDLE : src_rpt.stat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_addr  <= '0;
            pa_req   <= 1'b0;
            pa_rw    <= 1'b0;
            pa_id    <= 1'b0;
            pa_alloc <= 1'b0;
            pa_stat  <= '0;
        end else if (!act_capture) begin
            pa_addr  <= nxt_addr;
            pa_req   <= nxt_req;
            pa_rw    <= nxt_rw;
            pa_id    <= nxt_id;
            pa_alloc <= nxt_alloc;
            pa_stat  <= nxt_stat;
        end
    end

    p_jump_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && !half_rate && (ev_kind == K_BRANCH || ev_kind == K_TRAP))
        |=> pa_req && pa_rw && pa_id && pa_addr == $past(ev_addr));

    p_seq_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && !half_rate && ev_kind == K_SEQ)
        |=> pa_stat == S_SEQ && pa_addr == $past(mem_addr) && pa_req == $past(mem_req));

    p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && !half_rate && ev_kind == K_STORE)
        |=> pa_req && !pa_rw && !pa_id && pa_stat[2] && pa_stat[0]);

    p_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && !half_rate && (ev_kind == K_LOAD || ev_kind == K_STORE) && ev_alloc)
        |=> pa_alloc && pa_stat[2] && pa_stat[1]);

    p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> pa_stat == S_IDLE && !pa_alloc && pa_req == $past(mem_req)
                      && pa_addr == $past(mem_addr));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_capture |=> $stable(pa_addr) && $stable(pa_stat) && $stable(pa_req));

    p_mem_loses_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (act_commit && (ev_kind == K_LOAD || ev_kind == K_STORE))
        |=> pa_stat[2] || pa_stat[1]);

endmodule

// File: tb/trace_port_unit_tb_top.sv
`timescale 1ns/1ps
module trace_port_unit_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trace_en = 1'b0, half_rate = 1'b0;
    logic [2:0]    ev_kind = '0;
    logic [AW-1:0] ev_addr = '0;
    logic          ev_alloc = 1'b0;
    logic          mem_req = 1'b0, mem_rw = 1'b0, mem_id = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [AW-1:0] pa_addr;
    logic          pa_req, pa_rw, pa_id, pa_alloc;
    logic [2:0]    pa_stat;

    int tests = 0, fails = 0;
    bit chk_on = 0, done = 0;

    always #2.5 clk = ~clk;

    trace_port_unit #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .half_rate(half_rate),
        .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_alloc(ev_alloc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rw(mem_rw), .mem_id(mem_id),
        .pa_addr(pa_addr), .pa_req(pa_req), .pa_rw(pa_rw), .pa_id(pa_id),
        .pa_alloc(pa_alloc), .pa_stat(pa_stat)
    );

    // expected port image: {addr, req, rw, id, alloc, stat}
    logic [AW+6:0] exp_v = '0;
    string         tag = "R1";
    int            phase = 0;
    logic [2:0]    h_kind = '0;
    logic [AW-1:0] h_addr = '0;
    logic          h_alloc = 1'b0;

    function automatic int klass(logic [2:0] k);
        if (k == 3'd2 || k == 3'd3) return 3;
        if (k == 3'd4 || k == 3'd5) return 2;
        if (k == 3'd1) return 1;
        return 0;
    endfunction

    function automatic logic [AW+6:0] image(logic [2:0] k, logic [AW-1:0] a, logic al);
        case (k)
            3'd2: return {a, 4'b1110, 3'd2};
            3'd3: return {a, 4'b1110, 3'd3};
            3'd4: return {a, 3'b110, al, al ? 3'd6 : 3'd4};
            3'd5: return {a, 3'b100, al, al ? 3'd7 : 3'd5};
            3'd1: return {mem_addr, mem_req, mem_rw, mem_id, 1'b0, 3'd1};
            default: return {mem_addr, mem_req, mem_rw, mem_id, 1'b0, 3'd0};
        endcase
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v = '0; phase = 0; tag = "R1";
        end else if (!trace_en) begin
            exp_v = {mem_addr, mem_req, mem_rw, mem_id, 1'b0, 3'd0};
            phase = 0; tag = "R7";
        end else if (!half_rate) begin
            exp_v = image(ev_kind, ev_addr, ev_alloc);
            phase = 0;
            if (klass(ev_kind) == 3)      tag = "R2";
            else if (klass(ev_kind) == 2) tag = ev_alloc ? "R5" : "R4";
            else                          tag = "R3";
        end else if (phase == 0) begin
            h_kind = ev_kind; h_addr = ev_addr; h_alloc = ev_alloc;
            phase = 1; tag = "R8";
        end else begin
            if (klass(ev_kind) >= klass(h_kind)) exp_v = image(ev_kind, ev_addr, ev_alloc);
            else                                 exp_v = image(h_kind, h_addr, h_alloc);
            if (klass(ev_kind) == 3 && klass(h_kind) == 3)       tag = "R9";
            else if (klass(ev_kind) + klass(h_kind) == 5)       tag = "R10";
            else                                                tag = "R11";
            phase = 0;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            tests++;
            if ({pa_addr, pa_req, pa_rw, pa_id, pa_alloc, pa_stat} !== exp_v) begin
                fails++;
                $display("FAIL %s (R6 timing): actual addr=%h req=%b rw=%b id=%b alloc=%b stat=%0d expected addr=%h req=%b rw=%b id=%b alloc=%b stat=%0d",
                    tag, pa_addr, pa_req, pa_rw, pa_id, pa_alloc, pa_stat,
                    exp_v[AW+6:7], exp_v[6], exp_v[5], exp_v[4], exp_v[3], exp_v[2:0]);
            end
        end
    end

    task automatic run(input bit en, input bit hr, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trace_en  = en;
            half_rate = hr;
            ev_kind   = 3'($urandom_range(0, 7));
            ev_addr   = $urandom;
            ev_alloc  = 1'($urandom);
            mem_req   = 1'($urandom);
            mem_addr  = $urandom;
            mem_rw    = 1'($urandom);
            mem_id    = 1'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero while held in reset
        tests++;
        if ({pa_addr, pa_req, pa_rw, pa_id, pa_alloc, pa_stat} !== '0) begin
            fails++;
            $display("FAIL R1: actual %h expected 0",
                {pa_addr, pa_req, pa_rw, pa_id, pa_alloc, pa_stat});
        end
        chk_on = 1;
        rst_n  = 1'b1;
        run(1, 0, 400);   // R2 R3 R4 R5 R6
        run(0, 0, 150);   // R7
        run(1, 1, 600);   // R8 R9 R10 R11
        run(1, 0, 51);
        run(1, 1, 301);
        run(0, 1, 100);
        run(1, 1, 401);
        run(1, 0, 200);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule